// File: doc/BRIEF.md
# Narrow-Link Request Packet Serializer

This block takes one memory request at a time from a valid/ready interface and turns it into a packet. The request carries an address, a read/write flag and, for writes, a data word. The block sends the packet over a narrow, one-way request link of `LANES` data lanes. Each packet takes several link cycles. A read packet holds only a header, so it is shorter than a write packet, which also carries the data word. The last beat is padded with zeros when the packet length is not a multiple of the lane count.

The module also contains the receiving deserializer, wired directly to the link it drives. The link signals are brought out as ports so that they can be observed. The deserializer rebuilds the address, type and data from the beats and presents them with a one-cycle strobe. The block only accepts a new request when no packet is in flight.

Top module: `req_link_ser`

## Requirements
- R1: Packet bit 0 is the type (1 = write), bits `ADDR_W`:1 hold the address, and the next `DATA_W` bits hold the data word, for writes only. Every bit above these is zero. Beat k carries packet bits [k*LANES +: LANES], with lane 0 carrying the lowest bit.
- R2: A read occupies the link for ceil((1+ADDR_W)/LANES) consecutive cycles and a write for ceil((1+ADDR_W+DATA_W)/LANES) consecutive cycles. `link_vld` is high in exactly those cycles, and the first beat appears in the cycle after the accepting edge.
- R3: `link_sof` is high on the first beat of every packet and on no other cycle. It is never high while `link_vld` is low.
- R4: `in_ready` is high when idle and low in every cycle in which a beat is on the link. Request inputs presented while `in_ready` is low are never taken.
- R5: `rx_valid` is high for exactly one cycle, the cycle after the last beat. In that cycle `rx_write`, `rx_addr` and `rx_data` equal the accepted request.
- R6: For a read, `rx_data` is zero in the cycle `rx_valid` is high.
- R7: During and right after reset, `in_ready` is 1 and `link_vld`, `link_sof` and `rx_valid` are 0.
- R8: `link_lanes` is all zeros in every cycle in which `link_vld` is low. The lane widths 4, 8, 12, 16 and 32 are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request taken on this edge when in_valid is high |
| in_write | input | 1 | 1 = write, 0 = read |
| in_addr | input | ADDR_W | Target address |
| in_data | input | DATA_W | Write data, ignored for reads |
| link_lanes | output | LANES | Link data lanes |
| link_sof | output | 1 | First beat of a packet |
| link_vld | output | 1 | A beat is on the lanes |
| rx_valid | output | 1 | Rebuilt request strobe |
| rx_write | output | 1 | Rebuilt type |
| rx_addr | output | ADDR_W | Rebuilt address |
| rx_data | output | DATA_W | Rebuilt write data, zero for reads |

## Verification
With N beats in a packet, beat k is on the lanes between edges k and k+1 after the accepting edge. `rx_valid` follows at edge N, together with the return of `in_ready`. The bench computes N from the lane count and the request type. It drives inputs on falling edges and samples one falling edge per beat, then one more for the rebuilt request and another for the strobe to drop. Every sampled value is therefore compared in the cycle in which the requirements place it. During the beats the bench holds inverted request values on the inputs, and at the end it checks that no second packet started. It repeats this for five lane widths.

// File: rtl/req_link_ser.sv
module req_link_ser #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [LANES-1:0]  link_lanes,
  output logic              link_sof,
  output logic              link_vld,
  output logic              rx_valid,
  output logic              rx_write,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_data
);
  localparam int HDR_W    = 1 + ADDR_W;
  localparam int FULL_W   = HDR_W + DATA_W;
  localparam int RD_BEATS = (HDR_W + LANES - 1) / LANES;
  localparam int WR_BEATS = (FULL_W + LANES - 1) / LANES;
  localparam int PKT_W    = WR_BEATS * LANES;
  localparam int CNT_W    = $clog2(WR_BEATS + 1);

  logic              busy, first;
  logic [PKT_W-1:0]  sh;
  logic [CNT_W-1:0]  left;
  logic [FULL_W-1:0] pkt;

  assign pkt        = {(in_write ? in_data : {DATA_W{1'b0}}), in_addr, in_write};
  assign in_ready   = !busy;
  assign link_lanes = sh[LANES-1:0];
  assign link_sof   = first;
  assign link_vld   = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      first <= 1'b0;
      sh    <= '0;
      left  <= '0;
    end else if (busy) begin
      sh    <= sh >> LANES;
      first <= 1'b0;
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end else if (in_valid) begin
      busy  <= 1'b1;
      first <= 1'b1;
      sh    <= PKT_W'(pkt);
      left  <= in_write ? CNT_W'(WR_BEATS - 1) : CNT_W'(RD_BEATS - 1);
    end
  end

  logic [FULL_W-1:0] acc;
  logic [CNT_W-1:0]  idx, last;
  logic              done;
  logic [CNT_W-1:0]  len0;
  int                base;

  assign len0 = link_lanes[0] ? CNT_W'(WR_BEATS - 1) : CNT_W'(RD_BEATS - 1);
  assign base = link_sof ? 0 : int'(idx) * LANES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      idx  <= '0;
      last <= '0;
      done <= 1'b0;
    end else begin
      done <= link_vld && (link_sof ? (len0 == '0) : (idx == last));
      if (link_vld) begin
        if (link_sof) begin
          acc  <= '0;
          idx  <= CNT_W'(1);
          last <= len0;
        end else begin
          idx <= idx + 1'b1;
        end
        for (int b = 0; b < LANES; b++)
          if (base + b < FULL_W) acc[base + b] <= link_lanes[b];
      end
    end
  end

  assign rx_valid = done;
  assign rx_write = acc[0];
  assign rx_addr  = acc[ADDR_W:1];
  assign rx_data  = acc[HDR_W +: DATA_W];
endmodule

// File: rtl/req_link_ser_chk.sv
module req_link_ser_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LANES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LANES-1:0]  link_lanes,
  input logic              link_sof,
  input logic              link_vld,
  input logic              rx_valid,
  input logic              rx_write,
  input logic [DATA_W-1:0] rx_data
);
  localparam int RD_N = (1 + ADDR_W + LANES - 1) / LANES;
  localparam int WR_N = (1 + ADDR_W + DATA_W + LANES - 1) / LANES;

  logic [7:0] nbeat;
  logic       wtype;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbeat <= '0;
      wtype <= 1'b0;
    end else if (link_vld) begin
      nbeat <= link_sof ? 8'd1 : nbeat + 8'd1;
      if (link_sof) wtype <= link_lanes[0];
    end
  end

  p_sof_in_pkt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_sof |-> link_vld);
  p_idle_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_vld |-> link_lanes == '0);
  p_busy_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_vld |-> !in_ready);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (link_vld && link_sof));
  p_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_vld) |-> (nbeat == (wtype ? 8'(WR_N) : 8'(RD_N))));
  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_rx_after_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(link_vld));
  p_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_write) |-> rx_data == '0);
endmodule

bind req_link_ser req_link_ser_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .link_lanes(link_lanes), .link_sof(link_sof), .link_vld(link_vld),
  .rx_valid(rx_valid), .rx_write(rx_write), .rx_data(rx_data)
);

// File: tb/req_link_ser_test.sv
module req_link_ser_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NCFG = 5;
  localparam int NREQ = 30;
  localparam int LW [NCFG] = '{4, 8, 12, 16, 32};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  for (genvar g = 0; g < NCFG; g++) begin : cfg
    localparam int L = LW[g];
    localparam int RDN = (1 + AW + L - 1) / L;
    localparam int WRN = (1 + AW + DW + L - 1) / L;

    logic          in_valid = 1'b0, in_write = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, link_sof, link_vld, rx_valid, rx_write;
    logic [L-1:0]  link_lanes;
    logic [AW-1:0] rx_addr;
    logic [DW-1:0] rx_data;

    req_link_ser #(.ADDR_W(AW), .DATA_W(DW), .LANES(L)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_write(in_write), .in_addr(in_addr), .in_data(in_data),
      .link_lanes(link_lanes), .link_sof(link_sof), .link_vld(link_vld),
      .rx_valid(rx_valid), .rx_write(rx_write), .rx_addr(rx_addr), .rx_data(rx_data)
    );

    initial begin
      logic          w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [127:0]  p, mask, beat;
      int            n;
      @(posedge rst_n);
      @(negedge clk);
      chk(in_ready == 1'b1, $sformatf("R7 ready L=%0d", L), 64'(in_ready), 64'd1);
      chk(link_vld == 1'b0 && link_sof == 1'b0, $sformatf("R7 link idle L=%0d", L), 64'({link_vld, link_sof}), 64'd0);
      chk(rx_valid == 1'b0, $sformatf("R7 rx_valid L=%0d", L), 64'(rx_valid), 64'd0);
      chk(link_lanes == '0, $sformatf("R8 idle lanes L=%0d", L), 64'(link_lanes), 64'd0);
      for (int i = 0; i < NREQ; i++) begin
        case (i)
          0: begin w = 1'b0; a = '0;              d = '1; end
          1: begin w = 1'b1; a = '1;              d = '1; end
          2: begin w = 1'b0; a = '1;              d = '0; end
          3: begin w = 1'b1; a = 16'hA5C3;        d = '0; end
          default: begin w = 1'($urandom); a = AW'($urandom); d = DW'($urandom); end
        endcase
        in_valid = 1'b1; in_write = w; in_addr = a; in_data = d;
        @(negedge clk);
        p = 128'(w) | (128'(a) << 1) | (w ? (128'(d) << (1 + AW)) : 128'd0);
        n = w ? WRN : RDN;
        mask = (128'd1 << L) - 128'd1;
        in_write = ~w; in_addr = ~a; in_data = ~d;
        for (int k = 0; k < n; k++) begin
          beat = (p >> (k * L)) & mask;
          chk(link_vld == 1'b1, $sformatf("R2 beat %0d present L=%0d", k, L), 64'(link_vld), 64'd1);
          chk(64'(link_lanes) == beat[63:0], $sformatf("R1 beat %0d lanes L=%0d", k, L), 64'(link_lanes), beat[63:0]);
          chk(link_sof == (k == 0), $sformatf("R3 sof beat %0d L=%0d", k, L), 64'(link_sof), 64'(k == 0));
          chk(in_ready == 1'b0, $sformatf("R4 ready low L=%0d", L), 64'(in_ready), 64'd0);
          chk(rx_valid == 1'b0, $sformatf("R5 early rx L=%0d", L), 64'(rx_valid), 64'd0);
          @(negedge clk);
        end
        chk(link_vld == 1'b0, $sformatf("R2 end of packet L=%0d", L), 64'(link_vld), 64'd0);
        chk(link_lanes == '0, $sformatf("R8 lanes after packet L=%0d", L), 64'(link_lanes), 64'd0);
        chk(rx_valid == 1'b1, $sformatf("R5 rx strobe L=%0d", L), 64'(rx_valid), 64'd1);
        chk(rx_write == w, $sformatf("R5 rx type L=%0d", L), 64'(rx_write), 64'(w));
        chk(rx_addr == a, $sformatf("R5 rx addr L=%0d", L), 64'(rx_addr), 64'(a));
        chk(rx_data == (w ? d : '0), $sformatf("R6 rx data L=%0d", L), 64'(rx_data), 64'(w ? d : '0));
        chk(in_ready == 1'b1, $sformatf("R4 ready back L=%0d", L), 64'(in_ready), 64'd1);
        in_valid = 1'b0;
        @(negedge clk);
        chk(rx_valid == 1'b0, $sformatf("R5 single cycle L=%0d", L), 64'(rx_valid), 64'd0);
        chk(link_vld == 1'b0, $sformatf("R4 held inputs ignored L=%0d", L), 64'(link_vld), 64'd0);
      end
      done_cnt++;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (done_cnt == NCFG);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, NCFG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule